// File: doc/BRIEF.md
# Address-Masked GPIO Register Port

This block is an 8-pin general-purpose I/O port that sits behind a simple memory-mapped slave bus. The bus uses APB-style signals: select, enable, write, byte address, write data and read data. Each pin has a direction bit and an output value bit. A pad-facing output-enable vector and an output-value vector drive the pad cells.

Pin data is accessed through a window in the lower kilobyte of the address space. In that window the word address is itself a pin mask. A write changes only the pins whose mask bit is set. A read returns zero for every pin that is not selected. Software can therefore flip one pin with a single store and needs no read-modify-write.

Pad inputs pass through a two-flop synchroniser. The synchronised vector feeds the read path and is also brought out to a separate interrupt detector. The port holds that detector's configuration registers (sense, both-edges, event polarity, enable). It returns the detector's raw status and masked status when read. A write to the clear register produces a one-cycle clear pulse.

Top module: `mgpio_port`

## Requirements
- R1: After reset, all registers hold 0, pad_oe and pad_out are 0, irq_clear is 0 and prdata is 0.
- R2: A write at a word-aligned byte address below 0x400 updates pad_out bit n only when address bit n+2 is 1. All other output bits keep their value.
- R3: A read at a word-aligned byte address below 0x400 returns the synchronised pin value for each pin whose address bit n+2 is 1, and 0 for every other pin.
- R4: Offset 0x400 holds the direction register. Bit n = 1 makes pin n an output, and pad_oe equals this register.
- R5: pad_out always shows the output register, whatever the direction. A value written while a pin is an input appears on the pad as soon as its direction bit is set.
- R6: Offsets 0x404 (sense), 0x408 (both edges), 0x40C (event) and 0x410 (enable) are read/write. Each drives irq_sense, irq_both, irq_event and irq_enable respectively.
- R7: Offset 0x414 reads irq_raw. Offset 0x418 reads irq_raw AND the enable register.
- R8: A write to offset 0x41C drives its write data on irq_clear for exactly one cycle. At all other times irq_clear is 0, and a read of 0x41C returns 0.
- R9: Writes to 0x414, 0x418, unmapped offsets (0x420 and up) and addresses with byte-address bits [1:0] not 00 change no register. Reads from them return 0.
- R10: A change on pad_in appears on pins_sync exactly two rising clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase qualifier |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | NUM_PINS (8) | Write data |
| prdata | output | NUM_PINS (8) | Read data, registered during the setup phase |
| pad_in | input | NUM_PINS (8) | Asynchronous pad input values |
| pad_oe | output | NUM_PINS (8) | Per-pin output enable |
| pad_out | output | NUM_PINS (8) | Per-pin output value |
| pins_sync | output | NUM_PINS (8) | Synchronised pin values for the interrupt detector |
| irq_raw | input | NUM_PINS (8) | Raw interrupt status from the detector |
| irq_sense | output | NUM_PINS (8) | Level (1) or edge (0) sensing per pin |
| irq_both | output | NUM_PINS (8) | Trigger on both edges per pin |
| irq_event | output | NUM_PINS (8) | High/rising (1) or low/falling (0) per pin |
| irq_enable | output | NUM_PINS (8) | Interrupt enable per pin |
| irq_clear | output | NUM_PINS (8) | One-cycle clear pulse per pin |

## Verification
A write takes effect on the rising edge that closes the access phase. The bench therefore samples pad_oe, pad_out and irq_clear at the falling edge right after that edge. It then samples irq_clear once more, one cycle later, to see the pulse has gone. Read data is captured on the edge that ends the setup phase, so the bench compares prdata at the falling edge inside the access phase. Before any data-window read, the bench lets pad_in stay stable for three cycles, which covers the two synchroniser stages. A directed case samples pins_sync after one edge and after two edges to pin down the synchroniser depth.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  // Register slots above the data window; the slot order follows the address offsets.
  typedef enum logic [2:0] {
    RS_DIR    = 3'd0,
    RS_SENSE  = 3'd1,
    RS_BOTH   = 3'd2,
    RS_EVENT  = 3'd3,
    RS_ENABLE = 3'd4,
    RS_RAW    = 3'd5,
    RS_MASKED = 3'd6,
    RS_CLEAR  = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_CFG = 4;

  typedef struct packed {
    logic     wr;      // write access phase
    logic     rd;      // read setup phase
    logic     window;  // aligned access inside the data window
    logic     regs;    // aligned access inside the register block
    reg_sel_e sel;
  } bus_dec_t;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_in;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/mgpio_decode.sv
module mgpio_decode
  import mgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  output bus_dec_t            dec,
  output logic [NUM_PINS-1:0] mask
);
  localparam int unsigned PAGE_W = ADDR_W - 10;

  logic aligned;
  logic [PAGE_W-1:0] page;

  assign aligned = (paddr[1:0] == 2'b00);
  assign page    = paddr[ADDR_W-1:10];

  always_comb begin
    dec.wr     = psel && penable && pwrite;
    dec.rd     = psel && !penable && !pwrite;
    dec.window = aligned && (page == '0);
    dec.regs   = aligned && (page == PAGE_W'(1)) && (paddr[9:5] == 5'd0);
    dec.sel    = reg_sel_e'(paddr[4:2]);
  end

  assign mask = paddr[NUM_PINS+1:2];
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  bus_dec_t            dec,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] cfg_q [NUM_CFG],
  output logic [NUM_PINS-1:0] clear_q
);
  logic wr_win;
  logic wr_reg;

  assign wr_win = dec.wr && dec.window;
  assign wr_reg = dec.wr && dec.regs;

  // Output data: only masked bits change.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (wr_win) begin
      out_q <= (out_q & ~mask) | (wdata & mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (wr_reg && dec.sel == RS_DIR) begin
      dir_q <= wdata;
    end
  end

  // Interrupt configuration registers occupy consecutive slots after RS_DIR.
  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    localparam logic [2:0] SLOT = 3'(RS_SENSE) + 3'(c);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[c] <= '0;
      end else if (wr_reg && dec.sel == reg_sel_e'(SLOT)) begin
        cfg_q[c] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clear_q <= '0;
    end else if (wr_reg && dec.sel == RS_CLEAR) begin
      clear_q <= wdata;
    end else begin
      clear_q <= '0;
    end
  end
endmodule

// File: rtl/mgpio_rdata.sv
module mgpio_rdata
  import mgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  bus_dec_t            dec,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] cfg_q [NUM_CFG],
  input  logic [NUM_PINS-1:0] irq_raw,
  output logic [NUM_PINS-1:0] rdata_q
);
  logic [NUM_PINS-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (dec.window) begin
      rd_nxt = pins & mask;
    end else if (dec.regs) begin
      unique case (dec.sel)
        RS_DIR:    rd_nxt = dir_q;
        RS_SENSE:  rd_nxt = cfg_q[0];
        RS_BOTH:   rd_nxt = cfg_q[1];
        RS_EVENT:  rd_nxt = cfg_q[2];
        RS_ENABLE: rd_nxt = cfg_q[3];
        RS_RAW:    rd_nxt = irq_raw;
        RS_MASKED: rd_nxt = irq_raw & cfg_q[3];
        RS_CLEAR:  rd_nxt = '0;
        default:   rd_nxt = '0;
      endcase
    end
  end

  // Captured at the end of the setup phase so it is steady through the access phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (dec.rd) begin
      rdata_q <= rd_nxt;
    end
  end
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [NUM_PINS-1:0] pwdata,
  output logic [NUM_PINS-1:0] prdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pins_sync,
  input  logic [NUM_PINS-1:0] irq_raw,
  output logic [NUM_PINS-1:0] irq_sense,
  output logic [NUM_PINS-1:0] irq_both,
  output logic [NUM_PINS-1:0] irq_event,
  output logic [NUM_PINS-1:0] irq_enable,
  output logic [NUM_PINS-1:0] irq_clear
);
  bus_dec_t            dec;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] cfg_q [NUM_CFG];
  logic [NUM_PINS-1:0] clear_q;

  mgpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pad_in),
    .d_out (pins_sync)
  );

  mgpio_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) dec_i (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .dec     (dec),
    .mask    (mask)
  );

  mgpio_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .mask    (mask),
    .wdata   (pwdata),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .cfg_q   (cfg_q),
    .clear_q (clear_q)
  );

  mgpio_rdata #(.NUM_PINS(NUM_PINS)) rdata_i (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .mask    (mask),
    .pins    (pins_sync),
    .dir_q   (dir_q),
    .cfg_q   (cfg_q),
    .irq_raw (irq_raw),
    .rdata_q (prdata)
  );

  assign pad_oe     = dir_q;
  assign pad_out    = out_q;
  assign irq_sense  = cfg_q[0];
  assign irq_both   = cfg_q[1];
  assign irq_event  = cfg_q[2];
  assign irq_enable = cfg_q[3];
  assign irq_clear  = clear_q;
endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [ADDR_W-1:0]   paddr,
  input logic [NUM_PINS-1:0] pwdata,
  input logic [NUM_PINS-1:0] prdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pins_sync,
  input logic [NUM_PINS-1:0] irq_raw,
  input logic [NUM_PINS-1:0] irq_enable,
  input logic [NUM_PINS-1:0] irq_clear
);
  logic wr_acc, rd_set, aligned, in_win;
  logic [1:0] since_rst;

  assign wr_acc  = psel && penable && pwrite;
  assign rd_set  = psel && !penable && !pwrite;
  assign aligned = (paddr[1:0] == 2'b00);
  assign in_win  = aligned && (paddr[ADDR_W-1:10] == '0);

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && irq_enable == '0 && irq_clear == '0 && prdata == '0));

  p_window_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && in_win) |=> (((pad_out ^ $past(pad_out)) & ~$past(paddr[NUM_PINS+1:2])) == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> ($stable(pad_out) && $stable(pad_oe)));

  p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == ADDR_W'(12'h400)) |=> (pad_oe == $past(pwdata)));

  p_masked_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_set && paddr == ADDR_W'(12'h418)) |=> (prdata == $past(irq_raw & irq_enable)));

  p_clear_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_acc && paddr == ADDR_W'(12'h41C)) |=> (irq_clear == '0));

  p_sync_depth_r10: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (pins_sync == $past(pad_in, 2)));
endmodule

bind mgpio_port mgpio_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .prdata     (prdata),
  .pad_in     (pad_in),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pins_sync  (pins_sync),
  .irq_raw    (irq_raw),
  .irq_enable (irq_enable),
  .irq_clear  (irq_clear)
);

// File: tb/mgpio_port_tb_top.sv
`timescale 1ns/1ps
module mgpio_port_tb_top;
  localparam int NP = 8;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [NP-1:0] pwdata = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] irq_raw = '0;
  logic [NP-1:0] prdata, pad_oe, pad_out, pins_sync;
  logic [NP-1:0] irq_sense, irq_both, irq_event, irq_enable, irq_clear;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [NP-1:0] dir_m = '0, out_m = '0;
  logic [NP-1:0] cfg_m [4] = '{default: '0};

  always #2 clk = ~clk;

  mgpio_port dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pins_sync(pins_sync), .irq_raw(irq_raw),
    .irq_sense(irq_sense), .irq_both(irq_both), .irq_event(irq_event),
    .irq_enable(irq_enable), .irq_clear(irq_clear)
  );

  task automatic chk(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [NP-1:0] exp_read(input logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a[11:10] == 2'b00) return pad_in & a[9:2];
    if (a[11:10] != 2'b01 || a[9:5] != 0) return '0;
    case (a[4:2])
      3'd0: return dir_m;
      3'd1: return cfg_m[0];
      3'd2: return cfg_m[1];
      3'd3: return cfg_m[2];
      3'd4: return cfg_m[3];
      3'd5: return irq_raw;
      3'd6: return irq_raw & cfg_m[3];
      default: return '0;
    endcase
  endfunction

  function automatic string reg_tag(input logic [AW-1:0] a);
    if (a[1:0] != 0 || a[11:10] > 2'b01 || (a[11:10] == 2'b01 && a[9:5] != 0)) return "R9 unmapped read";
    if (a[11:10] == 2'b00) return "R3 window read";
    case (a[4:2])
      3'd0: return "R4 direction read";
      3'd5, 3'd6: return "R7 status read";
      3'd7: return "R8 clear read";
      default: return "R6 config read";
    endcase
  endfunction

  task automatic check_all_regs(input string tag);
    logic [NP-1:0] d;
    for (int i = 0; i < 8; i++) begin
      bus_read(12'h400 + 12'(i*4), d);
      chk(tag, d, exp_read(12'h400 + 12'(i*4)));
    end
    chk(tag, pad_out, out_m);
    chk(tag, pad_oe, dir_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 irq_clear", irq_clear, '0);
    chk("R1 irq_enable", irq_enable, '0);
    chk("R1 prdata", prdata, '0);
    check_all_regs("R1 reset regs");

    // R5 value preloaded while input, then direction set
    bus_write(12'h3FC, 8'hA5); out_m = 8'hA5;
    chk("R5 preload pad_out", pad_out, 8'hA5);
    chk("R5 preload pad_oe", pad_oe, 8'h00);
    bus_write(12'h400, 8'hFF); dir_m = 8'hFF;
    chk("R5 drive after dir pad_out", pad_out, 8'hA5);
    chk("R4 dir pad_oe", pad_oe, 8'hFF);

    // R2 single-pin write, mask bit 3 only (address 0x020)
    bus_write(12'h020, 8'h00); out_m[3] = 1'b0;
    chk("R2 single pin clear", pad_out, out_m);
    bus_write(12'h000, 8'hFF);
    chk("R2 empty mask write", pad_out, out_m);

    // R10 synchroniser depth
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); chk("R10 one edge", pins_sync, 8'h00);
    @(negedge clk); chk("R10 two edges", pins_sync, 8'h3C);

    // R3 read with partial mask
    bus_read(12'h0F0, d); chk("R3 partial mask", d, 8'h3C & 8'h3C);
    bus_read(12'h3FC, d); chk("R3 full mask", d, 8'h3C);

    // R8 clear pulse
    bus_write(12'h41C, 8'h81);
    chk("R8 pulse", irq_clear, 8'h81);
    @(negedge clk); chk("R8 pulse ends", irq_clear, 8'h00);

    // R9 ignored writes
    bus_write(12'h414, 8'hFF);
    bus_write(12'h418, 8'hFF);
    bus_write(12'h500, 8'hFF);
    bus_write(12'h401, 8'h00);
    bus_write(12'h3FE, 8'h00);
    check_all_regs("R9 ignored writes");
    bus_read(12'h420, d); chk("R9 unmapped read", d, 8'h00);
    bus_read(12'h3FD, d); chk("R9 misaligned read", d, 8'h00);
    bus_read(12'h800, d); chk("R9 high page read", d, 8'h00);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [NP-1:0] m, v;
      logic [AW-1:0] a;
      op = int'($urandom % 6);
      m = NP'($urandom); v = NP'($urandom);
      case (op)
        0: begin
          bus_write({2'b00, m, 2'b00}, v);
          out_m = (out_m & ~m) | (v & m);
          chk("R2 random window write", pad_out, out_m);
        end
        1: begin
          bus_write(12'h400, v); dir_m = v;
          chk("R4 random dir", pad_oe, dir_m);
          chk("R5 random pad_out", pad_out, out_m);
        end
        2: begin
          int c;
          c = int'($urandom % 4);
          bus_write(12'h404 + 12'(c*4), v); cfg_m[c] = v;
          chk("R6 sense out", irq_sense, cfg_m[0]);
          chk("R6 both out", irq_both, cfg_m[1]);
          chk("R6 event out", irq_event, cfg_m[2]);
          chk("R6 enable out", irq_enable, cfg_m[3]);
        end
        3: begin
          @(negedge clk); pad_in = v; irq_raw = NP'($urandom);
          repeat (3) @(negedge clk);
          a = {2'b00, m, 2'b00};
          bus_read(a, d); chk("R3 random window read", d, exp_read(a));
        end
        4: begin
          irq_raw = NP'($urandom);
          a = 12'h400 + 12'(($urandom % 8) * 4);
          if (($urandom % 5) == 0) a = 12'(($urandom % 4096));
          bus_read(a, d); chk(reg_tag(a), d, exp_read(a));
        end
        default: begin
          bus_write(12'h41C, v);
          chk("R8 random pulse", irq_clear, v);
          @(negedge clk); chk("R8 random pulse ends", irq_clear, 8'h00);
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule